// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a system-on-chip between its normal run mode and a ladder of five progressively deeper low-power modes. Software selects a target by presenting a mode code together with a request strobe while the controller is idle in run mode. The controller then walks through an ordered entry sequence: it gates clocks, asks the memory controller to enter self-refresh, asks the regulator for its minimum voltage, and finally removes platform power. It drives only the steps the chosen mode needs.

A wake interrupt brings the system back. Exit undoes the entry steps in strict reverse order, and each undo step waits for its handshake. Clocks are re-enabled only when power is good, the voltage is restored and self-refresh has been left. A handshake that never completes is cut off by a programmable cycle limit. A wake that arrives during entry unwinds the steps already taken. The deepest mode has no wake path: it holds a cold-reset output and leaves only through power-on reset.

Top module: `lpm_sequencer`

## Requirements
- R1: While `rst_n` is low, all three clock enables and `plat_pwr_en` are 1, `sr_req`, `vmin_req`, `busy_o`, `hs_err_o` and `req_err_o` are 0, `mode_o` is 0 and `cold_rst` is 1; `cold_rst` falls after the first clock edge with `rst_n` high.
- R2: Mode codes are 0 run, 1 wait, 2 doze, 3 retention, 4 deep sleep and 5 hibernate. At rest the outputs are as follows. Wait gates the core clock only. Doze also gates the bus clock, while the peripheral clock keeps running. Retention gates all three clocks and holds `sr_req` and `vmin_req`. Deep sleep adds `plat_pwr_en`=0. Hibernate adds `cold_rst`=1.
- R3: Entry takes one step per clock. The edge that accepts a request gates the clocks. The next edge raises `sr_req`. The edge that sees `sr_ack` raises `vmin_req`. The following edge drops `plat_pwr_en`. The next edge reaches rest.
- R4: Exit runs in reverse order. The first step raises `plat_pwr_en`, and the sequence waits for `pwr_good`. Next it drops `vmin_req` and waits for `vdd_ready`. Then it drops `sr_req` and waits for `sr_ack` low. Clocks are re-enabled only after that, on the following edge.
- R5: A `wake_irq` in wait, doze, retention or deep sleep returns the controller to run mode with all clocks enabled.
- R6: Hibernate ignores `wake_irq` and requests, and holds `cold_rst` high. Only `rst_n` leaves it.
- R7: If a handshake stays incomplete for `tmo_limit`+1 cycles in its waiting step, `hs_err_o` is set and the controller unwinds to run. `hs_err_o` stays set until reset.
- R8: A `wake_irq` during entry aborts it on the next edge and unwinds only the steps already taken.
- R9: Requests are accepted only in run mode. Codes 6 and 7 change no output except `req_err_o`, which is set and stays set until reset.
- R10: `mode_o` shows the target code during a transition and at rest (0 in run). `busy_o` is 1 exactly while a transition step is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| req_valid | input | 1 | Mode request strobe |
| req_code | input | 3 | Requested mode code |
| wake_irq | input | 1 | Any enabled interrupt |
| tmo_limit | input | TMO_W | Handshake timeout limit in cycles |
| sr_ack | input | 1 | Memory controller self-refresh acknowledge |
| vdd_ready | input | 1 | Regulator reports nominal voltage |
| pwr_good | input | 1 | Platform power switch reports power good |
| core_clk_en | output | 1 | Processor core clock enable |
| bus_clk_en | output | 1 | Bus-fabric clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| sr_req | output | 1 | Self-refresh request |
| vmin_req | output | 1 | Minimum-voltage request |
| plat_pwr_en | output | 1 | Platform power-switch enable |
| cold_rst | output | 1 | Cold-reset output |
| mode_o | output | 3 | Current or target mode code |
| busy_o | output | 1 | Transition in progress |
| hs_err_o | output | 1 | Sticky handshake-timeout flag |
| req_err_o | output | 1 | Sticky invalid-request flag |

## Verification
Every output is a register, so a request sampled on one edge shows its first effect (gated clocks) just after that edge. With handshakes answered at once, each later entry or exit step appears one edge after the previous one. The checks sample at the falling edge after the exact number of rising edges and look at each step of deep-sleep entry and exit in turn. A timeout appears on the rising edge that finds the wait counter at `tmo_limit`, that is `tmo_limit`+1 edges into the waiting step. The bench samples one edge before and one edge after that point. For the table-driven mode walk, the checks simply wait eight cycles so that every sequence has reached rest.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MD_RUN    = 3'd0;
    localparam logic [MODE_W-1:0] MD_WAIT   = 3'd1;
    localparam logic [MODE_W-1:0] MD_DOZE   = 3'd2;
    localparam logic [MODE_W-1:0] MD_RETAIN = 3'd3;
    localparam logic [MODE_W-1:0] MD_DEEP   = 3'd4;
    localparam logic [MODE_W-1:0] MD_HIBER  = 3'd5;

    typedef enum logic [3:0] {
        ST_RUN, ST_GATE, ST_SR_ON, ST_VMIN, ST_PWR_OFF,
        ST_SLEEP, ST_PWR_ON, ST_VREL, ST_SR_OFF, ST_HIBER
    } st_e;

    // what a mode needs: clock levels at rest plus the actions taken
    typedef struct packed {
        logic core;
        logic bus;
        logic per;
        logic sr;
        logic minv;
        logic pwroff;
        logic hiber;
        logic valid;
    } plan_t;

    typedef struct packed {
        st_e               state;
        logic [MODE_W-1:0] tgt;
        logic              core;
        logic              bus;
        logic              per;
        logic              sr;
        logic              minv;
        logic              pwr;
        logic              cold;
        logic              hs_err;
        logic              req_err;
    } ctl_t;

endpackage

// File: rtl/lpm_mode_plan.sv
`timescale 1ns/1ps
module lpm_mode_plan
    import lpm_pkg::*;
(
    input  logic [MODE_W-1:0] code,
    output plan_t             plan
);
    always_comb begin
        plan = '{core: 1'b1, bus: 1'b1, per: 1'b1, sr: 1'b0, minv: 1'b0,
                 pwroff: 1'b0, hiber: 1'b0, valid: 1'b1};
        case (code)
            MD_RUN:    ;
            MD_WAIT:   plan.core = 1'b0;
            MD_DOZE:   begin plan.core = 1'b0; plan.bus = 1'b0; end
            MD_RETAIN: begin
                plan.core = 1'b0; plan.bus = 1'b0; plan.per = 1'b0;
                plan.sr = 1'b1; plan.minv = 1'b1;
            end
            MD_DEEP:   begin
                plan.core = 1'b0; plan.bus = 1'b0; plan.per = 1'b0;
                plan.sr = 1'b1; plan.minv = 1'b1; plan.pwroff = 1'b1;
            end
            MD_HIBER:  begin
                plan.core = 1'b0; plan.bus = 1'b0; plan.per = 1'b0;
                plan.sr = 1'b1; plan.minv = 1'b1; plan.pwroff = 1'b1;
                plan.hiber = 1'b1;
            end
            default:   plan.valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpm_wait_timer.sv
`timescale 1ns/1ps
module lpm_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)             cnt_d = '0;
        else if (cnt_q != limit) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == limit);
endmodule

// File: rtl/lpm_sequencer.sv
`timescale 1ns/1ps
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_code,
    input  logic              wake_irq,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              sr_ack,
    input  logic              vdd_ready,
    input  logic              pwr_good,
    output logic              core_clk_en,
    output logic              bus_clk_en,
    output logic              per_clk_en,
    output logic              sr_req,
    output logic              vmin_req,
    output logic              plat_pwr_en,
    output logic              cold_rst,
    output logic [2:0]        mode_o,
    output logic              busy_o,
    output logic              hs_err_o,
    output logic              req_err_o
);
    localparam ctl_t CTL_RST = '{state: ST_RUN, tgt: MD_RUN, core: 1'b1, bus: 1'b1,
                                 per: 1'b1, sr: 1'b0, minv: 1'b0, pwr: 1'b1,
                                 cold: 1'b1, hs_err: 1'b0, req_err: 1'b0};

    ctl_t              d, q;
    plan_t             plan;
    logic [MODE_W-1:0] plan_code;
    logic              tmo;

    assign plan_code = (q.state == ST_RUN) ? req_code : q.tgt;

    lpm_mode_plan u_plan (
        .code (plan_code),
        .plan (plan)
    );

    lpm_wait_timer #(.CNT_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (d.state != q.state),
        .limit   (tmo_limit),
        .expired (tmo)
    );

    // next undo step, chosen from what is still applied
    function automatic ctl_t unwind(input ctl_t c);
        ctl_t r;
        r = c;
        if (!c.pwr) begin
            r.pwr = 1'b1;  r.state = ST_PWR_ON;
        end else if (c.minv) begin
            r.minv = 1'b0; r.state = ST_VREL;
        end else if (c.sr) begin
            r.sr = 1'b0;   r.state = ST_SR_OFF;
        end else begin
            r.core = 1'b1; r.bus = 1'b1; r.per = 1'b1;
            r.state = ST_RUN; r.tgt = MD_RUN;
        end
        return r;
    endfunction

    always_comb begin
        d = q;
        case (q.state)
            ST_RUN: if (req_valid) begin
                if (!plan.valid) begin
                    d.req_err = 1'b1;
                end else if (req_code != MD_RUN) begin
                    d.tgt   = req_code;
                    d.core  = plan.core;
                    d.bus   = plan.bus;
                    d.per   = plan.per;
                    d.state = ST_GATE;
                end
            end
            ST_GATE: begin
                if (wake_irq)     d = unwind(q);
                else if (plan.sr) begin d.sr = 1'b1; d.state = ST_SR_ON; end
                else              d.state = ST_SLEEP;
            end
            ST_SR_ON: begin
                if (wake_irq) d = unwind(q);
                else if (sr_ack) begin
                    if (plan.minv) begin d.minv = 1'b1; d.state = ST_VMIN; end
                    else           d.state = ST_SLEEP;
                end else if (tmo) begin
                    d = unwind(q);
                    d.hs_err = 1'b1;
                end
            end
            ST_VMIN: begin
                if (wake_irq)         d = unwind(q);
                else if (plan.pwroff) begin d.pwr = 1'b0; d.state = ST_PWR_OFF; end
                else                  d.state = ST_SLEEP;
            end
            ST_PWR_OFF: begin
                if (wake_irq)        d = unwind(q);
                else if (plan.hiber) d.state = ST_HIBER;
                else                 d.state = ST_SLEEP;
            end
            ST_SLEEP: if (wake_irq) d = unwind(q);
            ST_PWR_ON: begin
                if (pwr_good) d = unwind(q);
                else if (tmo) begin d = unwind(q); d.hs_err = 1'b1; end
            end
            ST_VREL: begin
                if (vdd_ready) d = unwind(q);
                else if (tmo)  begin d = unwind(q); d.hs_err = 1'b1; end
            end
            ST_SR_OFF: begin
                if (!sr_ack)  d = unwind(q);
                else if (tmo) begin d = unwind(q); d.hs_err = 1'b1; end
            end
            ST_HIBER: ;
            default:  d = CTL_RST;
        endcase
        d.cold = (d.state == ST_HIBER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign core_clk_en = q.core;
    assign bus_clk_en  = q.bus;
    assign per_clk_en  = q.per;
    assign sr_req      = q.sr;
    assign vmin_req    = q.minv;
    assign plat_pwr_en = q.pwr;
    assign cold_rst    = q.cold;
    assign mode_o      = q.tgt;
    assign busy_o      = !(q.state inside {ST_RUN, ST_SLEEP, ST_HIBER});
    assign hs_err_o    = q.hs_err;
    assign req_err_o   = q.req_err;
endmodule

// File: rtl/lpm_sequencer_chk.sv
`timescale 1ns/1ps
module lpm_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       core_clk_en,
    input logic       per_clk_en,
    input logic       sr_req,
    input logic       vmin_req,
    input logic       plat_pwr_en,
    input logic       cold_rst,
    input logic [2:0] mode_o,
    input logic       busy_o,
    input logic       hs_err_o,
    input logic       req_err_o
);
    assert_sr_after_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_req) |-> (!core_clk_en && !per_clk_en));

    assert_pwr_off_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(plat_pwr_en) |-> (vmin_req && sr_req && !core_clk_en));

    assert_ungate_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> (plat_pwr_en && !vmin_req && !sr_req));

    assert_hiber_cold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd5 && !busy_o) |-> (cold_rst && !plat_pwr_en));

    assert_hs_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hs_err_o |=> hs_err_o);

    assert_req_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_err_o |=> req_err_o);

    assert_busy_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (mode_o != 3'd0));
endmodule

bind lpm_sequencer lpm_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_clk_en (core_clk_en),
    .per_clk_en  (per_clk_en),
    .sr_req      (sr_req),
    .vmin_req    (vmin_req),
    .plat_pwr_en (plat_pwr_en),
    .cold_rst    (cold_rst),
    .mode_o      (mode_o),
    .busy_o      (busy_o),
    .hs_err_o    (hs_err_o),
    .req_err_o   (req_err_o)
);

// File: tb/lpm_sequencer_bench.sv
`timescale 1ns/1ps
module lpm_sequencer_bench;
    localparam int TMO_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_code = 3'd0;
    logic wake_irq = 1'b0;
    logic [TMO_W-1:0] tmo_limit = 8'd20;
    logic ack_en = 1'b1, pg_en = 1'b1, vr_en = 1'b1;
    logic sr_ack, vdd_ready, pwr_good;
    logic core_clk_en, bus_clk_en, per_clk_en, sr_req, vmin_req, plat_pwr_en, cold_rst;
    logic [2:0] mode_o;
    logic busy_o, hs_err_o, req_err_o;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // responders answer immediately when enabled
    assign sr_ack    = sr_req & ack_en;
    assign pwr_good  = plat_pwr_en & pg_en;
    assign vdd_ready = ~vmin_req & vr_en;

    lpm_sequencer #(.TMO_W(TMO_W)) u_lpm_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .wake_irq(wake_irq), .tmo_limit(tmo_limit), .sr_ack(sr_ack),
        .vdd_ready(vdd_ready), .pwr_good(pwr_good), .core_clk_en(core_clk_en),
        .bus_clk_en(bus_clk_en), .per_clk_en(per_clk_en), .sr_req(sr_req),
        .vmin_req(vmin_req), .plat_pwr_en(plat_pwr_en), .cold_rst(cold_rst),
        .mode_o(mode_o), .busy_o(busy_o), .hs_err_o(hs_err_o), .req_err_o(req_err_o)
    );

    // {core,bus,per,sr,minv,pwr,cold,busy,mode}
    localparam logic [10:0] OBS_RUN  = 11'b111_001_0_0_000;
    localparam logic [10:0] OBS_HIB  = 11'b000_110_1_0_101;

    // {code, expected levels at rest}
    localparam logic [13:0] VEC [6] = '{
        {3'd1, 11'b011_001_0_0_001},
        {3'd2, 11'b001_001_0_0_010},
        {3'd3, 11'b000_111_0_0_011},
        {3'd4, 11'b000_110_0_0_100},
        {3'd0, OBS_RUN},
        {3'd6, OBS_RUN}
    };

    function automatic logic [10:0] obs();
        return {core_clk_en, bus_clk_en, per_clk_en, sr_req, vmin_req,
                plat_pwr_en, cold_rst, busy_o, mode_o};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] code);
        req_code = code; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wake();
        wake_irq = 1'b1;
        @(negedge clk);
        wake_irq = 1'b0;
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        cyc(3);
        chk("R1 reset outputs", obs(), 11'b111_001_1_0_000);
        chk("R1 reset errors", {hs_err_o, req_err_o}, 2'b00);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 cold_rst released", obs(), OBS_RUN);

        // R2 R5 R10 table walk
        for (int i = 0; i < 6; i++) begin
            issue(VEC[i][13:11]);
            cyc(8);
            chk("R2 rest levels", obs(), VEC[i][10:0]);
            wake();
            cyc(8);
            chk("R5 back to run", obs(), OBS_RUN);
        end
        chk("R9 invalid code flagged", req_err_o, 1'b1);

        // R3 entry order, one step per edge
        issue(3'd4);
        chk("R3 clocks gated first", obs(), 11'b000_001_0_1_100);
        cyc(1);
        chk("R3 sr_req second", obs(), 11'b000_101_0_1_100);
        cyc(1);
        chk("R3 vmin third", obs(), 11'b000_111_0_1_100);
        cyc(1);
        chk("R3 power off fourth", obs(), 11'b000_110_0_1_100);
        cyc(1);
        chk("R3 at rest", obs(), 11'b000_110_0_0_100);
        // R4 exit order
        wake();
        chk("R4 power on first", obs(), 11'b000_111_0_1_100);
        cyc(1);
        chk("R4 vmin released", obs(), 11'b000_101_0_1_100);
        cyc(1);
        chk("R4 sr released", obs(), 11'b000_001_0_1_100);
        cyc(1);
        chk("R4 clocks last", obs(), OBS_RUN);

        // R4 clocks wait for power good
        issue(3'd4);
        cyc(8);
        pg_en = 1'b0;
        wake();
        cyc(5);
        chk("R4 held without pwr_good", obs(), 11'b000_111_0_1_100);
        pg_en = 1'b1;
        cyc(6);
        chk("R4 released after pwr_good", obs(), OBS_RUN);
        chk("R7 no timeout yet", hs_err_o, 1'b0);

        // R9 request outside run is ignored
        issue(3'd1);
        cyc(4);
        issue(3'd2);
        cyc(4);
        chk("R9 request in wait ignored", obs(), 11'b011_001_0_0_001);
        wake();
        cyc(4);

        // R8 wake during entry
        ack_en = 1'b0;
        issue(3'd4);
        cyc(1);
        wake();
        chk("R8 abort undoes sr only", obs(), 11'b000_001_0_1_100);
        cyc(1);
        chk("R8 back to run", obs(), OBS_RUN);
        chk("R8 no error on abort", hs_err_o, 1'b0);

        // R7 timeout
        tmo_limit = 8'd3;
        issue(3'd3);
        cyc(4);
        chk("R7 before limit", {hs_err_o, sr_req}, 2'b01);
        cyc(1);
        chk("R7 timeout unwinds", {hs_err_o, sr_req, busy_o}, 3'b101);
        cyc(1);
        chk("R7 run after timeout", obs(), OBS_RUN);
        cyc(3);
        chk("R7 flag sticky", hs_err_o, 1'b1);
        ack_en = 1'b1;
        tmo_limit = 8'd20;

        // R9 code 7 ignored
        issue(3'd7);
        cyc(2);
        chk("R9 code 7 no effect", obs(), OBS_RUN);

        // R6 hibernate
        issue(3'd5);
        cyc(8);
        chk("R6 hibernate levels", obs(), OBS_HIB);
        wake();
        cyc(8);
        chk("R6 wake ignored", obs(), OBS_HIB);
        rst_n = 1'b0;
        cyc(1);
        chk("R6 reset holds cold", cold_rst, 1'b1);
        rst_n = 1'b1;
        cyc(1);
        chk("R6 cold boot to run", obs(), OBS_RUN);
        chk("R1 errors cleared", {hs_err_o, req_err_o}, 2'b00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        done = 1'b1;
        $finish;
    end
endmodule